// File: doc/BRIEF.md
# Dual-Clock FIFO with Runtime-Programmable Threshold Flags

This block is a first-in first-out buffer of 256 words, each 9 bits wide. It sits between two unrelated clock domains: words enter on the write clock and leave on the read clock. Besides the usual full and empty indications, it drives two active-low threshold flags. The near-full flag is computed in the write domain from an offset `m`. It goes low once the stored count reaches 256 minus `m`. The near-empty flag is computed in the read domain from an offset `n`. It goes low once the stored count drops to `n` or below.

Write and read positions cross between the domains as Gray-coded pointers through two-flop synchronizers. Each flag therefore follows the other side's activity a few cycles late.

The second write-enable pin has two uses, chosen by its level while reset is held:
- If it is low during reset, the pin acts as a second write enable.
- If it is high during reset, the pin acts as a load strobe. The offsets can then be rewritten over the write data bus in a fixed cyclic order of four steps.

Reset is synchronous and active high. It must be held across several edges of both clocks.

Top module: `async_flag_fifo`

## Requirements
- R1: While reset is held and after its release: `empty`=1, `ae_n`=0, `full`=0, `af_n`=1, `rd_data`=0, both offsets are 7, and the load sequence is at its first step.
- R2: Words leave in the order they entered, with all 9 bits intact. `rd_data` takes the next word on the read-clock edge that accepts a read.
- R3: A write attempted while `full`=1 is dropped. The write pointer does not move, and the dropped word never appears at the output.
- R4: A read attempted while `empty`=1 is ignored. The read pointer does not move and `rd_data` keeps its value.
- R5: In quiescent operation, `full`=1 exactly when 256 words are stored and `empty`=1 exactly when none are stored. Each flag is updated on the edge of its own domain that changes the count.
- R6: `af_n`=0 exactly when the stored count is at least 256−m. It is updated on write-clock edges.
- R7: `ae_n`=0 exactly when the stored count is at most n. It is updated on read-clock edges.
- R8: The level of `wr_en_b_ld` during reset selects the mode.
  - Low (normal mode): a write needs `wr_en_a`=1 and `wr_en_b_ld`=1.
  - High (load mode): a write needs `wr_en_a`=1 with `wr_en_b_ld`=0. `wr_en_a`=1 with `wr_en_b_ld`=1 loads one offset part and stores no word.
- R9: Load cycles fill the offsets cyclically in this order: step 0 sets n bits [7:0] from `wr_data[7:0]`; step 1 sets the n upper part; step 2 sets m bits [7:0]; step 3 sets the m upper part. After step 3 the sequence returns to step 0. With 256 words the offsets are 8 bits wide, so the upper parts have no effect.
- R10: Pointers cross domains as Gray code that changes at most one bit per edge, through two flops. After a write into an empty FIFO, `empty` stays 1 on at least the first two read-clock edges that follow.
- R11: A read needs both `rd_en_a`=1 and `rd_en_b`=1. With either one low, nothing is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held over edges of both clocks |
| wr_en_a | input | 1 | First write enable |
| wr_en_b_ld | input | 1 | Second write enable or load strobe; its level during reset picks which |
| wr_data | input | 9 | Write data, also carries offset parts when loading |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_data | output | 9 | Registered read data |
| full | output | 1 | High when 256 words are held (write domain) |
| af_n | output | 1 | Low when count ≥ 256−m (write domain) |
| empty | output | 1 | High when no word is held (read domain) |
| ae_n | output | 1 | Low when count ≤ n (read domain) |

## Verification
The assertions check, on every cycle:
- A full FIFO never advances the write pointer, and an empty FIFO never advances the read pointer.
- A load cycle never moves the write pointer.
- Each Gray pointer changes by at most one bit per edge.
- A full FIFO always shows the near-full flag, and an empty FIFO always shows the near-empty flag.

Some behaviour depends on data and sequence, so only the bench scenarios can show it:
- data order;
- the exact counts at which the threshold flags switch;
- the order of the offset-load steps and their wrap back to the first step;
- the two enable modes;
- the lag of `empty` behind a fresh write.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
    localparam int DATA_W  = 9;
    localparam int ADDR_W  = 8;
    localparam int PTR_W   = ADDR_W + 1;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int PART_W  = 8;
    localparam int DEF_OFS = 7;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [ADDR_W-1:0] ofs_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        ptr_t bin;
        ptr_t gray;
    } ptr_pair_t;

    typedef enum logic [1:0] {
        STEP_AE_LO,
        STEP_AE_HI,
        STEP_AF_LO,
        STEP_AF_HI
    } ld_step_e;

    function automatic ptr_t bin2gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t r;
        r[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            r[i] = r[i+1] ^ g[i];
        end
        return r;
    endfunction

    // Merge one offset part from the data bus into an offset value.
    function automatic ofs_t part_merge(input ofs_t cur, input word_t d, input logic hi);
        ofs_t r = cur;
        for (int i = 0; i < PART_W && i < ADDR_W; i++) begin
            if (!hi) r[i] = d[i];
        end
        for (int i = PART_W; i < ADDR_W; i++) begin
            if (hi) r[i] = d[i-PART_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem
    import afifo_pkg::*;
(
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic              rclk,
    input  logic              rst,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);
    word_t ram [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) ram[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= ram[raddr];
    end
endmodule

// File: rtl/afifo_wside.sv
module afifo_wside
    import afifo_pkg::*;
(
    input  logic              wclk,
    input  logic              rst,
    input  logic              wr_en_a,
    input  logic              wr_en_b_ld,
    input  word_t             wr_data,
    input  ptr_t              rgray_s,
    output ptr_pair_t         wp,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic              full,
    output logic              af_n,
    output ofs_t              ae_ofs,
    output logic              ld_fire
);
    localparam ptr_t DEPTH_P = ptr_t'(DEPTH);

    logic     ld_mode;
    ld_step_e step;
    ofs_t     af_ofs;
    logic     wr_req;
    ptr_t     wbin_nx, rbin_s, cnt_nx, af_thr;

    always_comb begin
        ld_fire = ld_mode & wr_en_a & wr_en_b_ld;
        wr_req  = ld_mode ? (wr_en_a & ~wr_en_b_ld) : (wr_en_a & wr_en_b_ld);
        we      = wr_req & ~full;
        wbin_nx = wp.bin + ptr_t'(we);
        rbin_s  = gray2bin(rgray_s);
        cnt_nx  = wbin_nx - rbin_s;
        af_thr  = DEPTH_P - {1'b0, af_ofs};
        waddr   = wp.bin[ADDR_W-1:0];
    end

    always_ff @(posedge wclk) begin
        if (rst) begin
            ld_mode <= wr_en_b_ld;
            wp      <= '0;
            full    <= 1'b0;
            af_n    <= 1'b1;
            step    <= STEP_AE_LO;
            ae_ofs  <= ofs_t'(DEF_OFS);
            af_ofs  <= ofs_t'(DEF_OFS);
        end else begin
            wp.bin  <= wbin_nx;
            wp.gray <= bin2gray(wbin_nx);
            full    <= (cnt_nx == DEPTH_P);
            af_n    <= !(cnt_nx >= af_thr);
            if (ld_fire) begin
                unique case (step)
                    STEP_AE_LO: ae_ofs <= part_merge(ae_ofs, wr_data, 1'b0);
                    STEP_AE_HI: ae_ofs <= part_merge(ae_ofs, wr_data, 1'b1);
                    STEP_AF_LO: af_ofs <= part_merge(af_ofs, wr_data, 1'b0);
                    STEP_AF_HI: af_ofs <= part_merge(af_ofs, wr_data, 1'b1);
                    default:    af_ofs <= af_ofs;
                endcase
                step <= ld_step_e'(step + 2'd1);
            end
        end
    end
endmodule

// File: rtl/afifo_rside.sv
module afifo_rside
    import afifo_pkg::*;
(
    input  logic              rclk,
    input  logic              rst,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  ptr_t              wgray_s,
    input  ofs_t              ae_ofs,
    output ptr_pair_t         rp,
    output logic              re,
    output logic [ADDR_W-1:0] raddr,
    output logic              empty,
    output logic              ae_n
);
    ptr_t rbin_nx, wbin_s, cnt_nx;

    always_comb begin
        re      = rd_en_a & rd_en_b & ~empty;
        rbin_nx = rp.bin + ptr_t'(re);
        wbin_s  = gray2bin(wgray_s);
        cnt_nx  = wbin_s - rbin_nx;
        raddr   = rp.bin[ADDR_W-1:0];
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rp    <= '0;
            empty <= 1'b1;
            ae_n  <= 1'b0;
        end else begin
            rp.bin  <= rbin_nx;
            rp.gray <= bin2gray(rbin_nx);
            empty   <= (cnt_nx == '0);
            ae_n    <= !(cnt_nx <= {1'b0, ae_ofs});
        end
    end
endmodule

// File: rtl/async_flag_fifo.sv
module async_flag_fifo
    import afifo_pkg::*;
(
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              wr_en_a,
    input  logic              wr_en_b_ld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              af_n,
    output logic              empty,
    output logic              ae_n
);
    ptr_pair_t         wp, rp;
    ptr_t              wgray_s, rgray_s;
    logic              we, re, ld_fire;
    logic [ADDR_W-1:0] waddr, raddr;
    ofs_t              ae_ofs;

    afifo_wside u_wside (
        .wclk(wclk), .rst(rst), .wr_en_a(wr_en_a), .wr_en_b_ld(wr_en_b_ld),
        .wr_data(wr_data), .rgray_s(rgray_s), .wp(wp), .we(we), .waddr(waddr),
        .full(full), .af_n(af_n), .ae_ofs(ae_ofs), .ld_fire(ld_fire)
    );

    afifo_rside u_rside (
        .rclk(rclk), .rst(rst), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
        .wgray_s(wgray_s), .ae_ofs(ae_ofs), .rp(rp), .re(re), .raddr(raddr),
        .empty(empty), .ae_n(ae_n)
    );

    afifo_sync #(.W(PTR_W)) u_w2r (.clk(rclk), .rst(rst), .d(wp.gray), .q(wgray_s));
    afifo_sync #(.W(PTR_W)) u_r2w (.clk(wclk), .rst(rst), .d(rp.gray), .q(rgray_s));

    afifo_mem u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rclk(rclk), .rst(rst), .re(re), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: rtl/afifo_chk.sv
module afifo_chk
    import afifo_pkg::*;
(
    input logic      wclk,
    input logic      rclk,
    input logic      rst,
    input logic      full,
    input logic      af_n,
    input logic      empty,
    input logic      ae_n,
    input logic      ld_fire,
    input ptr_pair_t wp,
    input ptr_pair_t rp
);
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (rst)
        full |=> wp.bin == $past(wp.bin));

    p_no_underflow_r4: assert property (@(posedge rclk) disable iff (rst)
        empty |=> rp.bin == $past(rp.bin));

    p_full_shows_af_r6: assert property (@(posedge wclk) disable iff (rst)
        full |-> !af_n);

    p_empty_shows_ae_r7: assert property (@(posedge rclk) disable iff (rst)
        empty |-> !ae_n);

    p_load_stores_nothing_r8: assert property (@(posedge wclk) disable iff (rst)
        ld_fire |=> wp.bin == $past(wp.bin));

    p_wgray_one_bit_r10: assert property (@(posedge wclk) disable iff (rst)
        $countones(wp.gray ^ $past(wp.gray)) <= 1);

    p_rgray_one_bit_r10: assert property (@(posedge rclk) disable iff (rst)
        $countones(rp.gray ^ $past(rp.gray)) <= 1);
endmodule

bind async_flag_fifo afifo_chk u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .full(full), .af_n(af_n),
    .empty(empty), .ae_n(ae_n), .ld_fire(ld_fire), .wp(wp), .rp(rp)
);

// File: tb/async_flag_fifo_test.sv
module async_flag_fifo_test;
    logic       wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic       wr_en_a = 1'b0, wr_en_b_ld = 1'b0, rd_en_a = 1'b0, rd_en_b = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       full, af_n, empty, ae_n;

    always #4 wclk = ~wclk;   // 125 MHz write clock
    always #6 rclk = ~rclk;   // unrelated read clock

    async_flag_fifo uut (
        .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en_a(wr_en_a), .wr_en_b_ld(wr_en_b_ld),
        .wr_data(wr_data), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_data(rd_data),
        .full(full), .af_n(af_n), .empty(empty), .ae_n(ae_n)
    );

    // Behavioural reference
    logic [8:0] q[$];
    int         m_ofs, n_ofs, step_m;
    bit         ld_mode_m;
    logic [8:0] last_rd;
    int         checks = 0, errors = 0;
    bit         done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit af_exp();
        return !(q.size() >= 256 - m_ofs);
    endfunction
    function automatic bit ae_exp();
        return !(q.size() <= n_ofs);
    endfunction

    task automatic chk_wside(input string tag);
        chk(full == (q.size() == 256), {tag, " R5 full"}, full, int'(q.size() == 256));
        chk(af_n == af_exp(), {tag, " R6 af_n"}, af_n, af_exp());
    endtask
    task automatic chk_rside(input string tag);
        chk(empty == (q.size() == 0), {tag, " R5 empty"}, empty, int'(q.size() == 0));
        chk(ae_n == ae_exp(), {tag, " R7 ae_n"}, ae_n, ae_exp());
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
        @(negedge wclk);
        chk_wside("settled");
        @(negedge rclk);
        chk_rside("settled");
    endtask

    task automatic do_reset(input bit load_mode);
        @(negedge wclk);
        rst = 1'b1; wr_en_a = 1'b0; wr_en_b_ld = load_mode;
        rd_en_a = 1'b0; rd_en_b = 1'b0;
        repeat (8) @(negedge wclk);
        @(negedge rclk);
        chk(empty == 1'b1 && ae_n == 1'b0, "R1 read flags in reset", {empty, ae_n}, 2);
        chk(rd_data == 9'd0, "R1 rd_data in reset", rd_data, 0);
        @(negedge wclk);
        chk(full == 1'b0 && af_n == 1'b1, "R1 write flags in reset", {full, af_n}, 1);
        rst = 1'b0; wr_en_b_ld = 1'b0;
        q.delete(); m_ofs = 7; n_ofs = 7; step_m = 0; ld_mode_m = load_mode; last_rd = '0;
        settle();
    endtask

    task automatic wr(input logic [8:0] d, input bit en_b);
        @(negedge wclk);
        wr_en_a = 1'b1; wr_en_b_ld = ld_mode_m ? 1'b0 : en_b; wr_data = d;
        @(negedge wclk);
        wr_en_a = 1'b0; wr_en_b_ld = 1'b0;
        if ((ld_mode_m || en_b) && q.size() < 256) q.push_back(d); // R3 / R8
        chk_wside("write R3 R8");
    endtask

    task automatic ld(input logic [8:0] d);
        @(negedge wclk);
        wr_en_a = 1'b1; wr_en_b_ld = 1'b1; wr_data = d;
        @(negedge wclk);
        wr_en_a = 1'b0; wr_en_b_ld = 1'b0;
        case (step_m)                      // R9 order
            0: n_ofs = int'(d[7:0]);
            2: m_ofs = int'(d[7:0]);
            default: ;                     // upper parts: no effect at 8-bit offsets
        endcase
        step_m = (step_m + 1) % 4;
        chk_wside("load R8 R9");
    endtask

    task automatic rd(input bit en_b);
        @(negedge rclk);
        rd_en_a = 1'b1; rd_en_b = en_b;
        @(negedge rclk);
        rd_en_a = 1'b0; rd_en_b = 1'b0;
        if (en_b && q.size() > 0) begin
            last_rd = q.pop_front();
            chk(rd_data == last_rd, "R2 read data order", rd_data, last_rd);
        end else begin
            chk(rd_data == last_rd, "R4 R11 read ignored keeps data", rd_data, last_rd);
        end
        chk_rside("read R7 R11");
    endtask

    initial begin
        // Normal mode: both write enables needed
        do_reset(1'b0);
        for (int i = 0; i < 10; i++) begin
            wr(9'((i * 37 + 5) % 512), 1'b1);
            if (i == 4) wr(9'h1FF, 1'b0);  // R8: single enable stores nothing
        end
        settle();
        for (int i = 0; i < 10; i++) begin
            rd(1'b1);
            if (i == 2) rd(1'b0);          // R11: single read enable reads nothing
        end
        rd(1'b1); rd(1'b1);                // R4: reads on empty
        settle();

        // R10: empty lags a fresh write; R4: pointer did not move on empty reads
        wr(9'h0AA, 1'b1);
        @(negedge rclk);
        chk(empty == 1'b1, "R10 empty lags write", empty, 1);
        settle();
        rd(1'b1);
        settle();

        // Fill past capacity, R3 and R6 with default m=7
        for (int i = 0; i < 260; i++) wr(9'(i + 100), 1'b1);
        settle();
        for (int i = 0; i < 256; i++) rd(1'b1);
        rd(1'b1);
        settle();

        // Load mode: program n=20, m=30 (upper parts ignored)
        do_reset(1'b1);
        ld(9'd20); ld(9'h55); ld(9'd30); ld(9'h0AA);
        for (int i = 0; i < 230; i++) wr(9'(i * 3), 1'b0);
        settle();
        ld(9'd200);                        // R9: wrap to first step, n=200
        settle();
        for (int i = 0; i < 231; i++) rd(1'b1);
        settle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule